// File: doc/BRIEF.md
# Burst-Stride Region Address Scanner

This block produces the write address for a memory client that fills a rectangular window of SDRAM one burst at a time. Each pulse on the count input moves the column forward by one burst of words. When the window's column span is used up, the column goes back to zero and the row moves down by one. After the final burst of the final row, the scan returns to the window's origin, so it repeats indefinitely with no outside help.

The window covers rows 0 to 199 and columns 0 to 199. The burst length is 8 words. Because 200 is not a power of two, neither dimension wraps on a natural binary rollover. The first column of each burst is therefore one of 0, 8, ... 192, and each row holds 25 bursts.

The output is one packed word in the layout a row/bank/column SDRAM controller decodes. The bank bits come straight from an input, which the base configuration ties to zero. The row limit, column limit and stride are parameters. The field widths are parameters as well.

Top module: `region_burst_scanner`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next state is row 0, column 0. Reset is synchronous and active low.
- R2: A high `count_burst` moves the column up by 8 in the same row. This applies when the current column is below 192, and the new address appears after that clock edge.
- R3: A high `count_burst` while the column is 192 sets the column to 0 and the row to the current row plus one. This applies when the row is below 199.
- R4: A high `count_burst` at row 199, column 192 returns the scan to row 0, column 0.
- R5: While `count_burst` is low, the row and column keep their values.
- R6: `addr_out` is packed as row in bits 23:11, bank in bits 10:9 and column in bits 8:0.
- R7: The bank field of `addr_out` follows `bank_sel` in the same cycle with no register delay. A change of `bank_sel` has no effect on the row or column.
- R8: The column is always a multiple of 8 no greater than 192. The row never exceeds 199.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| count_burst | input | 1 | One-cycle pulse: advance the address by one burst |
| bank_sel | input | 2 | Bank number placed in the address word |
| addr_out | output | 24 | Packed {row, bank, column} address |

## Verification
Two things can happen on the same edge: the column rolls over and the row advances or wraps. At row 199, column 192, a single pulse must clear both fields together. The bench drives long runs of random pulses so that the scan crosses the full window more than once, and it also forces pulses directly onto the last burst of the last row. Each cycle, the bench compares the packed word with a model built from the requirements. The bank input changes at random in the same cycles as the pulses, so a bank change that corrupts the row or column is caught by the model.

// File: rtl/scan_pkg.sv
// Package: shared defaults and the unpacked address view for the region scanner.
// Assumes: field widths match the SDRAM controller's packed address layout.
package scan_pkg;
    localparam int ROW_BITS  = 13;
    localparam int BANK_BITS = 2;
    localparam int COL_BITS  = 9;

    typedef struct packed {
        logic [ROW_BITS-1:0]  row;
        logic [BANK_BITS-1:0] bank;
        logic [COL_BITS-1:0]  col;
    } scan_addr_t;
endpackage

// File: rtl/burst_col_stepper.sv
// Column stepper: advances the column by STRIDE on each pulse. It returns to 0
// after the last burst start that fits under COL_LAST and raises a carry for the row.
// Assumes: STRIDE > 0 and COL_LAST < 2**COL_W - STRIDE.
module burst_col_stepper #(
    parameter int COL_W    = 9,
    parameter int COL_LAST = 199,
    parameter int STRIDE   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [COL_W-1:0] col,
    output logic             carry
);
    localparam int              LAST_START_I = (COL_LAST / STRIDE) * STRIDE;
    localparam logic [COL_W-1:0] LAST_START  = COL_W'(LAST_START_I);
    localparam logic [COL_W-1:0] STEP        = COL_W'(STRIDE);

    logic at_last;

    // Flag the final burst start of a row.
    always_comb at_last = (col == LAST_START);

    // Carry to the row stepper when a pulse leaves the last burst start.
    always_comb carry = step && at_last;

    // Column register: reset, wrap or advance by one burst.
    always_ff @(posedge clk) begin
        if (!rst_n)       col <= '0;
        else if (carry)   col <= '0;
        else if (step)    col <= col + STEP;
    end

    AST_COL_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !at_last) |=> (col == $past(col) + STEP)); // R2
    AST_COL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        carry |=> (col == '0)); // R3
    AST_COL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(col)); // R5
    AST_COL_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
        (col <= LAST_START) && ((int'(col) % STRIDE) == 0)); // R8
endmodule

// File: rtl/region_row_stepper.sv
// Row stepper: increments the row on each column carry and returns to 0 after ROW_LAST.
// Assumes: ROW_LAST < 2**ROW_W - 1.
module region_row_stepper #(
    parameter int ROW_W    = 13,
    parameter int ROW_LAST = 199
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [ROW_W-1:0] row
);
    localparam logic [ROW_W-1:0] LAST = ROW_W'(ROW_LAST);

    // Row register: reset, wrap at the last row or increment on carry.
    always_ff @(posedge clk) begin
        if (!rst_n)                  row <= '0;
        else if (inc && row == LAST) row <= '0;
        else if (inc)                row <= row + 1'b1;
    end

    AST_ROW_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && row != LAST) |=> (row == $past(row) + 1'b1)); // R3
    AST_ROW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && row == LAST) |=> (row == '0)); // R4
    AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(row)); // R5
    AST_ROW_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
        row <= LAST); // R8
endmodule

// File: rtl/scan_addr_packer.sv
// Packer: joins row, bank and column into the controller's address word.
// Assumes: bank is combinational from the input, with no register.
module scan_addr_packer
    import scan_pkg::*;
(
    input  logic [ROW_BITS-1:0]  row,
    input  logic [BANK_BITS-1:0] bank,
    input  logic [COL_BITS-1:0]  col,
    output scan_addr_t           packed_addr
);
    // Place each field in its position.
    always_comb begin
        packed_addr.row  = row;
        packed_addr.bank = bank;
        packed_addr.col  = col;
    end
endmodule

// File: rtl/region_burst_scanner.sv
// Top: scans a ROW_LAST+1 by COL_LAST+1 region one burst per count pulse.
// Assumes: count_burst is a synchronous one-cycle pulse; bank_sel may change at any cycle.
module region_burst_scanner
    import scan_pkg::*;
#(
    parameter int ROW_LAST = 199,
    parameter int COL_LAST = 199,
    parameter int STRIDE   = 8
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 count_burst,
    input  logic [BANK_BITS-1:0]                 bank_sel,
    output logic [ROW_BITS+BANK_BITS+COL_BITS-1:0] addr_out
);
    logic [COL_BITS-1:0] col_q;
    logic [ROW_BITS-1:0] row_q;
    logic                col_carry;
    scan_addr_t          word;

    burst_col_stepper #(
        .COL_W(COL_BITS), .COL_LAST(COL_LAST), .STRIDE(STRIDE)
    ) u_col (
        .clk(clk), .rst_n(rst_n), .step(count_burst), .col(col_q), .carry(col_carry)
    );

    region_row_stepper #(
        .ROW_W(ROW_BITS), .ROW_LAST(ROW_LAST)
    ) u_row (
        .clk(clk), .rst_n(rst_n), .inc(col_carry), .row(row_q)
    );

    scan_addr_packer u_pack (
        .row(row_q), .bank(bank_sel), .col(col_q), .packed_addr(word)
    );

    // Drive the port from the packed word.
    always_comb addr_out = word;

    AST_RESET_ORIGIN: assert property (@(posedge clk)
        !rst_n |=> (addr_out[23:11] == '0 && addr_out[8:0] == '0)); // R1
    AST_BANK_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_burst && !$stable(bank_sel)) |=>
        ($stable(addr_out[23:11]) || !$stable(bank_sel))); // R7
endmodule

// File: tb/tb_region_burst_scanner.sv
module tb_region_burst_scanner;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        count_burst = 1'b0;
    logic [1:0]  bank_sel = 2'b00;
    logic [23:0] addr_out;

    int checks = 0;
    int fails  = 0;
    int m_row  = 0;
    int m_col  = 0;
    bit finished = 0;

    region_burst_scanner dut (
        .clk(clk), .rst_n(rst_n), .count_burst(count_burst),
        .bank_sel(bank_sel), .addr_out(addr_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [23:0] pack_exp(int r, logic [1:0] b, int c);
        return {13'(r), b, 9'(c)};
    endfunction

    // Model update from the requirements (R1..R5).
    task automatic model_edge(bit rst, bit pulse);
        if (rst) begin m_row = 0; m_col = 0; end
        else if (pulse) begin
            if (m_col == 192) begin
                m_col = 0;
                m_row = (m_row == 199) ? 0 : m_row + 1;
            end else m_col = m_col + 8;
        end
    endtask

    task automatic check(string req, logic [23:0] exp);
        checks++;
        if (addr_out !== exp) begin
            fails++;
            $display("FAIL %s: addr_out=%h expected=%h", req, addr_out, exp);
        end
    endtask

    // One cycle: drive at negedge, model at posedge, compare at the next negedge.
    task automatic cyc(bit rst, bit pulse, logic [1:0] b, string req);
        rst_n = !rst; count_burst = pulse; bank_sel = b;
        @(posedge clk);
        model_edge(rst, pulse);
        @(negedge clk);
        count_burst = 1'b0;
        check(req, pack_exp(m_row, b, m_col));
    endtask

    // Drive pulses until the model reaches (r, c).
    task automatic go_to(int r, int c);
        while (!(m_row == r && m_col == c)) cyc(0, 1, 2'b00, "R2");
    endtask

    initial begin
        void'($urandom(32'h5A17));
        @(negedge clk);
        cyc(1, 0, 2'b00, "R1");
        cyc(1, 1, 2'b00, "R1");
        // R5 hold with no pulse, and R7 bank change alone
        cyc(0, 0, 2'b00, "R5");
        cyc(0, 0, 2'b11, "R7");
        checks++;
        if (addr_out[10:9] !== 2'b11) begin
            fails++; $display("FAIL R6: bank bits=%b expected=11", addr_out[10:9]);
        end
        // immediate bank follow within the cycle
        bank_sel = 2'b10; #1; check("R7", pack_exp(m_row, 2'b10, m_col));
        cyc(0, 1, 2'b01, "R2");
        cyc(0, 1, 2'b10, "R6");
        // row carry at column 192
        go_to(0, 192);
        cyc(0, 1, 2'b00, "R3");
        // corner: last burst of last row
        go_to(199, 192);
        cyc(0, 0, 2'b00, "R5");
        cyc(0, 1, 2'b01, "R4");
        // reset in the middle of a scan
        for (int i = 0; i < 37; i++) cyc(0, 1, 2'b00, "R2");
        cyc(1, 1, 2'b00, "R1");
        // random mix across more than one full sweep
        for (int i = 0; i < 14000; i++) begin
            bit p = ($urandom % 4) != 0;
            logic [1:0] b = 2'($urandom);
            bit r = ($urandom % 5000) == 0;
            cyc(r, p, b, p ? "R8" : "R5");
        end
        go_to(199, 192);
        cyc(0, 1, 2'b11, "R4");
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: cycles=%0d expected completion", WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule